// File: doc/BRIEF.md
# E3 G.832 Synchronization Status Message Receive Assembler

This block sits behind an E3 frame aligner. It takes in the maintenance-and-adaptation overhead byte of every G.832 frame, marked by a one-cycle valid strobe. Each such byte carries a single bit of the 4-bit synchronization status message in its least significant bit. A 2-bit field beside that bit says which message position the bit belongs to. The block decodes that field and places each bit into a shadow word by position. It publishes the complete message only after all four positions have arrived in order, in consecutive overhead bytes.

Two read outputs form a register-style view. One is the last complete message. The other is the position index decoded from the most recent accepted byte. Reception needs three conditions: the line-type select must choose E3, the format select must choose G.832, and the receive enable must be set. When any of these is missing, incoming bytes are ignored and any partial message is dropped. The published message keeps its last value.

Top module: `e3_ssm_rx_assembler`

## Requirements
- R1: A synchronous active-high reset sets `ssm_word` and `mf_index` to zero and discards any partial message.
- R2: The block accepts a byte when `ma_valid` is 1 and the block is active. In the cycle after an accepted byte, `mf_index` equals the byte's position field `ma_byte[2:1]`. Byte bit 6 is `ma_byte[2]` and bit 7 is `ma_byte[1]`.
- R3: `ma_byte[0]` carries the message bit. Field value 0 carries the message MSB (`ssm_word[3]`), 1 carries `ssm_word[2]`, 2 carries `ssm_word[1]`, and 3 carries the LSB (`ssm_word[0]`).
- R4: `ssm_word` changes only in the cycle after accepted bytes with fields 0, 1, 2 and 3 have arrived as four consecutive accepted bytes. It holds its value while a message is partly collected.
- R5: An accepted byte whose field does not follow the expected sequence discards the partial message. Collection resumes only at the next accepted byte with field 0.
- R6: An accepted byte with field 0 always restarts collection, even in the middle of a message.
- R7: While `rx_en` is 0, incoming bytes have no effect on `ssm_word` or `mf_index`.
- R8: The block is active only when `sel_ds3` is 0 and `fmt_g832` is 1. In every other combination, bytes have no effect on either output.
- R9: Any cycle in which the block is inactive clears the partial message. Collection after reactivation must start again from field 0.
- R10: Cycles with `ma_valid` low are ignored. Idle cycles between accepted bytes do not break a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ma_byte | input | 8 | Overhead byte of the current frame |
| ma_valid | input | 1 | One-cycle strobe marking `ma_byte` as valid |
| sel_ds3 | input | 1 | Line-type select, 0 selects E3 |
| fmt_g832 | input | 1 | Frame-format select, 1 selects G.832 |
| rx_en | input | 1 | Receive enable for message collection |
| ssm_word | output | 4 | Last completely received message |
| mf_index | output | 2 | Position field of the latest accepted byte |

## Verification
The bench sweeps all sixteen message values through ordered four-byte sequences, with varied filler in the unused byte bits. This shows whether each bit lands in its own position and whether the output stays put until the fourth byte. Every out-of-sequence field at every step is tried, followed by the remaining correct bytes. Each aborted sequence uses a message different from the one held, so a wrongly resumed collection would be visible. Disabled, wrong-mode, interrupted and gapped sequences separate the three ways reception can be gated from a simple pause in the strobe.

// File: rtl/ssm_rx_pkg.sv
package ssm_rx_pkg;
    localparam int BYTE_W = 8;
    localparam int SSM_W  = 4;
    localparam int IDX_W  = $clog2(SSM_W);
    localparam logic [IDX_W-1:0] IDX_FIRST = '0;
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(SSM_W - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             bit_val;
    } ma_field_t;

    typedef struct packed {
        logic             armed;
        logic [IDX_W-1:0] expect_idx;
    } seq_state_t;

    function automatic ma_field_t decode_ma(input logic [BYTE_W-1:0] b);
        ma_field_t f;
        f.idx     = b[IDX_W:1];
        f.bit_val = b[0];
        return f;
    endfunction

    function automatic int slot_of(input logic [IDX_W-1:0] idx);
        return SSM_W - 1 - int'(idx);
    endfunction
endpackage

// File: rtl/ssm_mode_gate.sv
module ssm_mode_gate (
    input  logic sel_ds3,
    input  logic fmt_g832,
    input  logic rx_en,
    output logic active
);
    always_comb begin
        active = (~sel_ds3) & fmt_g832 & rx_en;
    end
endmodule

// File: rtl/ssm_ma_decode.sv
module ssm_ma_decode
    import ssm_rx_pkg::*;
(
    input  logic [BYTE_W-1:0] ma_byte,
    input  logic              ma_valid,
    input  logic              active,
    output logic              accept,
    output ma_field_t         field
);
    always_comb begin
        field  = decode_ma(ma_byte);
        accept = ma_valid & active;
    end
endmodule

// File: rtl/ssm_shadow_assembler.sv
module ssm_shadow_assembler
    import ssm_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             accept,
    input  ma_field_t        field,
    output logic             done,
    output logic [SSM_W-1:0] done_word
);
    seq_state_t       st;
    logic [SSM_W-1:0] shadow;
    logic             in_seq;

    always_comb begin
        in_seq = st.armed && (field.idx == st.expect_idx);
        done   = accept && (field.idx != IDX_FIRST) && in_seq && (field.idx == IDX_LAST);
    end

    genvar g;
    generate
        for (g = 0; g < SSM_W; g++) begin : g_slot
            always_comb begin
                done_word[g] = (slot_of(field.idx) == g) ? field.bit_val : shadow[g];
            end

            always_ff @(posedge clk) begin
                if (rst || !active) begin
                    shadow[g] <= 1'b0;
                end else if (accept) begin
                    if (field.idx == IDX_FIRST) begin
                        shadow[g] <= (g == SSM_W - 1) ? field.bit_val : 1'b0;
                    end else if (in_seq && slot_of(field.idx) == g) begin
                        shadow[g] <= field.bit_val;
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            st <= '0;
        end else if (accept) begin
            if (field.idx == IDX_FIRST) begin
                st.armed      <= 1'b1;
                st.expect_idx <= IDX_W'(1);
            end else if (in_seq && field.idx != IDX_LAST) begin
                st.expect_idx <= st.expect_idx + IDX_W'(1);
            end else begin
                st <= '0;
            end
        end
    end

    AST_DISARM_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !active |=> !st.armed) else $error("partial message survived inactivity"); // R9

    AST_REARM_ON_FIRST: assert property (@(posedge clk) disable iff (rst)
        (accept && field.idx == IDX_FIRST) |=> (st.armed && st.expect_idx == IDX_W'(1))) else $error("field 0 did not restart"); // R6

    AST_MISMATCH_DROPS: assert property (@(posedge clk) disable iff (rst)
        (accept && field.idx != IDX_FIRST && !in_seq) |=> !st.armed) else $error("out-of-order byte kept partial"); // R5
endmodule

// File: rtl/e3_ssm_rx_assembler.sv
module e3_ssm_rx_assembler
    import ssm_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       ma_byte,
    input  logic             ma_valid,
    input  logic             sel_ds3,
    input  logic             fmt_g832,
    input  logic             rx_en,
    output logic [3:0]       ssm_word,
    output logic [1:0]       mf_index
);
    logic             active;
    logic             accept;
    ma_field_t        field;
    logic             done;
    logic [SSM_W-1:0] done_word;

    ssm_mode_gate u_gate (
        .sel_ds3  (sel_ds3),
        .fmt_g832 (fmt_g832),
        .rx_en    (rx_en),
        .active   (active)
    );

    ssm_ma_decode u_dec (
        .ma_byte  (ma_byte),
        .ma_valid (ma_valid),
        .active   (active),
        .accept   (accept),
        .field    (field)
    );

    ssm_shadow_assembler u_asm (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .accept    (accept),
        .field     (field),
        .done      (done),
        .done_word (done_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ssm_word <= '0;
            mf_index <= '0;
        end else begin
            if (accept) mf_index <= field.idx;
            if (done)   ssm_word <= done_word;
        end
    end

    AST_WORD_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(ssm_word)) else $error("message changed without completion"); // R4

    AST_MF_HOLD_UNACCEPTED: assert property (@(posedge clk) disable iff (rst)
        !(ma_valid && !sel_ds3 && fmt_g832 && rx_en) |=> $stable(mf_index)) else $error("index moved on ignored byte"); // R7

    AST_MF_TRACKS_BYTE: assert property (@(posedge clk) disable iff (rst)
        accept |=> (mf_index == $past(ma_byte[2:1]))) else $error("index not taken from byte"); // R2

    AST_LSB_FROM_LAST: assert property (@(posedge clk) disable iff (rst)
        done |=> (ssm_word[0] == $past(ma_byte[0]))) else $error("LSB not from final byte"); // R3
endmodule

// File: tb/tb_e3_ssm_rx_assembler.sv
module tb_e3_ssm_rx_assembler;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] ma_byte;
    logic       ma_valid;
    logic       sel_ds3;
    logic       fmt_g832;
    logic       rx_en;
    logic [3:0] ssm_word;
    logic [1:0] mf_index;

    int checks = 0;
    int errors = 0;
    logic [3:0] held;
    logic [1:0] held_mf;

    e3_ssm_rx_assembler dut (
        .clk(clk), .rst(rst), .ma_byte(ma_byte), .ma_valid(ma_valid),
        .sel_ds3(sel_ds3), .fmt_g832(fmt_g832), .rx_en(rx_en),
        .ssm_word(ssm_word), .mf_index(mf_index)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] idx, input logic b, input logic [4:0] fill);
        @(negedge clk);
        ma_byte  = {fill, idx, b};
        ma_valid = 1'b1;
        @(negedge clk);
        ma_valid = 1'b0;
        ma_byte  = 8'hFF;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_word(input logic [3:0] w, input logic [4:0] fill);
        for (int k = 0; k < 4; k++) send(2'(k), w[3-k], fill + 5'(k));
    endtask

    initial begin
        #(20ns * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; ma_byte = 8'h00; ma_valid = 1'b0;
        sel_ds3 = 1'b0; fmt_g832 = 1'b1; rx_en = 1'b1;
        idle(3);
        // R1: reset state
        check("R1 word", ssm_word, 0);
        check("R1 mf", mf_index, 0);
        rst = 1'b0;
        idle(1);

        // R2 R3 R4: sweep every message value
        held = 4'h0;
        for (int w = 0; w < 16; w++) begin
            logic [3:0] v;
            v = 4'(w ^ 4'h9);
            for (int k = 0; k < 4; k++) begin
                send(2'(k), v[3-k], 5'(w * 3 + k * 7));
                check("R2 mf", mf_index, k);
                check((k == 3) ? "R3 word" : "R4 hold", ssm_word, (k == 3) ? v : held);
            end
            held = v;
        end

        // R5: every wrong field at every step
        for (int k = 1; k < 4; k++) begin
            for (int wr = 1; wr < 4; wr++) begin
                if (wr != k) begin
                    logic [3:0] p;
                    p = held ^ 4'hF;
                    for (int j = 0; j < k; j++) send(2'(j), p[3-j], 5'h0A);
                    send(2'(wr), p[3-wr], 5'h15);
                    for (int j = k; j < 4; j++) send(2'(j), p[3-j], 5'h03);
                    check("R5 abort", ssm_word, held);
                    send_word(p, 5'h11);
                    check("R5 recover", ssm_word, p);
                    held = p;
                end
            end
        end

        // R6: field 0 mid-message restarts
        send(2'd0, 1'b0, 5'h1); send(2'd1, 1'b0, 5'h1);
        send_word(4'hB, 5'h2);
        check("R6 restart", ssm_word, 4'hB);
        held = 4'hB;
        send(2'd0, 1'b0, 5'h1); send(2'd1, 1'b1, 5'h1);
        send(2'd0, 1'b1, 5'h1); send(2'd2, 1'b0, 5'h1); send(2'd3, 1'b0, 5'h1);
        check("R6 old partial gone", ssm_word, held);
        send_word(4'h6, 5'h4);
        held = 4'h6;

        // R7: enable low
        held_mf = mf_index;
        rx_en = 1'b0;
        send_word(4'h9, 5'h7);
        check("R7 word", ssm_word, held);
        check("R7 mf", mf_index, held_mf);
        send(2'd1, 1'b1, 5'h0);
        check("R7 mf single", mf_index, held_mf);
        rx_en = 1'b1;

        // R8: every inactive mode combination
        for (int m = 0; m < 4; m++) begin
            sel_ds3  = m[0];
            fmt_g832 = m[1];
            if (!(sel_ds3 == 1'b0 && fmt_g832 == 1'b1)) begin
                send_word(4'h9, 5'h9);
                check("R8 word", ssm_word, held);
                send(2'd1, 1'b0, 5'h9);
                check("R8 mf", mf_index, held_mf);
            end
        end
        sel_ds3 = 1'b0; fmt_g832 = 1'b1;

        // R9: inactive cycle drops partial
        send(2'd0, 1'b1, 5'h2); send(2'd1, 1'b1, 5'h2);
        @(negedge clk); rx_en = 1'b0;
        @(negedge clk); rx_en = 1'b1;
        send(2'd2, 1'b1, 5'h2); send(2'd3, 1'b1, 5'h2);
        check("R9 dropped", ssm_word, held);
        send_word(4'hD, 5'h5);
        check("R9 resume", ssm_word, 4'hD);
        held = 4'hD;

        // R10: strobe low ignored, gaps allowed
        @(negedge clk);
        ma_byte = {5'h1F, 2'd2, 1'b1};
        ma_valid = 1'b0;
        idle(3);
        check("R10 mf", mf_index, 3);
        check("R10 word", ssm_word, held);
        for (int k = 0; k < 4; k++) begin
            send(2'(k), 4'h2 >> (3 - k), 5'h6);
            idle(k + 2);
        end
        check("R10 gapped", ssm_word, 4'h2);

        // R1: reset after activity
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 word again", ssm_word, 0);
        check("R1 mf again", mf_index, 0);
        send(2'd1, 1'b1, 5'h0); send(2'd2, 1'b1, 5'h0); send(2'd3, 1'b1, 5'h0);
        check("R1 partial cleared", ssm_word, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule